// File: doc/BRIEF.md
# CAN Receive Identifier Filter Mode Controller

This block is the mode and configuration front end of a receive-side CAN identifier filter. It holds a three-bit mode word that selects one of three modes. In the halted mode every frame is discarded. In the pass-through mode every frame is taken. In the screening mode each frame is passed to an external identifier search engine, and the block waits for that engine's verdict. The mode word also carries an enable for an enhanced receive feature, which the block passes on to downstream logic.

The block also owns five 10-bit section boundary registers and the 512-word identifier lookup memory that the search engine walks. Each boundary register holds a plain word offset into that memory. While screening is active, the table and its boundaries must not move under the engine. The block therefore drops writes to both during screening and flags any attempt on the memory. Software reaches the block through a word-wide register port with address, write enable, read enable and a ready pulse. Frames arrive on a valid/ready handshake, and a verdict comes out as a one-cycle decision pulse.

Top module: `can_afilt_mode_ctrl`

## Requirements
- R1: After reset the mode word reads 0x1 (halted), every boundary register reads 0, `engine_halt` is 1 and `frm_ready` is 1.
- R2: A write to address 0x400 stores bits 2:0 of `bus_wdata` as the mode word: bit 0 is halt, bit 1 is pass-through and bit 2 is the enhanced enable. Bits 31:3 are dropped and read back as 0. A mode write is taken in every mode.
- R3: While bit 0 is set (regardless of bit 1), each frame handshake produces, one cycle later, `dec_valid`=1 with `dec_accept`=0. `engine_halt` is 1 and no search is started.
- R4: While bit 1 is set and bit 0 is clear, each frame handshake produces `dec_valid`=1 with `dec_accept`=1 one cycle later. `engine_halt` is 1.
- R5: With bits 1:0 both clear (screening), a frame handshake raises `srch_start` for one cycle on the following cycle. `frm_ready` then stays 0, and no decision is issued, until the engine answers.
- R6: In screening, `dec_valid` pulses one cycle after `match_valid`, with `dec_accept` equal to `match_hit`. `frm_ready` is 1 again in that same cycle.
- R7: Setting bit 0 while a verdict is pending abandons it. `frm_ready` is 1 by the second cycle after the write is accepted, and any later `match_valid` gives no decision.
- R8: Boundary register k (k=1..5) sits at address 0x400+k and holds 10 bits, read back zero-extended and also driven on `sec_bound[10k-1:10k-10]`. A write to it is taken only when bit 0 or bit 1 of the mode word is set; in screening the old value stays. Reads work in every mode.
- R9: A write to lookup word i (address i, i<512) stores the full 32-bit word when bit 0 or bit 1 is set. In screening the word is left unchanged and `lut_err` pulses for one cycle, one cycle after the write.
- R10: A read of lookup word i returns the last stored word in every mode. Accesses are whole words only.
- R11: `bus_ready` pulses one cycle after each cycle with `bus_we` or `bus_re` high, and `bus_rdata` holds the read data in that cycle.
- R12: `enh_rx_en` is 1 exactly when bit 2 is set and the block is screening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 11 | Word address; bit 10 selects register space, otherwise lookup word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completion pulse |
| frm_valid | input | 1 | A received frame is offered |
| frm_ready | output | 1 | Frame can be taken (low while a verdict is pending) |
| srch_start | output | 1 | Start pulse to the external search engine |
| match_valid | input | 1 | Search engine result strobe |
| match_hit | input | 1 | Search engine found the identifier |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Decision: 1 accept, 0 reject |
| engine_halt | output | 1 | Search engine held in reset (halted or pass-through) |
| enh_rx_en | output | 1 | Enhanced receive enable toward downstream logic |
| sec_bound | output | 50 | Five 10-bit section boundaries, boundary 1 in the low bits |
| lut_err | output | 1 | Blocked lookup-memory write |

## Verification
Every result has a fixed latency. A bus access completes, and a blocked-write error pulses, one cycle after the strobe. A new mode takes effect in the cycle after the write. Halted and pass-through decisions come one cycle after the frame handshake, and a screening decision one cycle after `match_valid`. The bench drives on falling edges and samples on the next falling edge, exactly the number of cycles later that the latency calls for. It also checks that no decision appears in the cycles between, and that none appears at all after an abandoned search. The sweeps cover every boundary register and a spread of lookup words, including the first and the last. Screening is exercised with answer delays of zero to three cycles and with both verdicts.

// File: rtl/can_afilt_pkg.sv
package can_afilt_pkg;

   typedef enum logic [1:0] {
      AFM_SCREEN = 2'd0,
      AFM_PASS   = 2'd1,
      AFM_HALT   = 2'd2
   } afm_e;

   typedef enum logic {
      DS_IDLE = 1'b0,
      DS_WAIT = 1'b1
   } dstate_e;

   localparam int unsigned MODE_BITS = 3;
   localparam int unsigned HALT_BIT  = 0;
   localparam int unsigned PASS_BIT  = 1;
   localparam int unsigned ENH_BIT   = 2;

   localparam logic [MODE_BITS-1:0] MODE_RESET = 3'b001;

   // halt dominates pass-through
   function automatic afm_e afm_decode(input logic [MODE_BITS-1:0] m);
      if (m[HALT_BIT])      return AFM_HALT;
      else if (m[PASS_BIT]) return AFM_PASS;
      else                  return AFM_SCREEN;
   endfunction

endpackage

// File: rtl/can_afilt_mode_reg.sv
module can_afilt_mode_reg
   import can_afilt_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DW-1:0]        wdata,
   output logic [MODE_BITS-1:0] mode_bits,
   output afm_e                 mode,
   output logic                 enh_en
);

   generate
      if (DW < MODE_BITS) begin : g_bad_dw
         $error("mode register needs a data width of at least MODE_BITS");
      end
   endgenerate

   logic [MODE_BITS-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= MODE_RESET;
      else if (wr_en) mode_q <= wdata[MODE_BITS-1:0];
   end

   assign mode_bits = mode_q;
   assign mode      = afm_decode(mode_q);
   assign enh_en    = mode_q[ENH_BIT] && (mode == AFM_SCREEN);

endmodule

// File: rtl/can_afilt_sect_bank.sv
module can_afilt_sect_bank #(
   parameter int unsigned SEC_N = 5,
   parameter int unsigned SEC_W = 10,
   localparam int unsigned IDX_W = (SEC_N > 1) ? $clog2(SEC_N) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   cfg_open,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [SEC_W-1:0]       wdata,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [SEC_W-1:0]       rd_val,
   output logic [SEC_N*SEC_W-1:0] bound
);

   generate
      if (SEC_N == 0) begin : g_bad_n
         $error("section bank needs at least one register");
      end
   endgenerate

   logic [SEC_W-1:0] sec_q [SEC_N];

   for (genvar g = 0; g < SEC_N; g++) begin : g_sec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sec_q[g] <= '0;
         else if (wr_en && cfg_open && (wr_idx == IDX_W'(g)))
            sec_q[g] <= wdata;
      end
      assign bound[g*SEC_W +: SEC_W] = sec_q[g];
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < SEC_N; i++)
         if (rd_idx == IDX_W'(i)) rd_val = sec_q[i];
   end

endmodule

// File: rtl/can_afilt_lut.sv
module can_afilt_lut #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned DW    = 32,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic          cfg_open,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          err
);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("lookup memory depth must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rdata_q;
   logic          err_q;

   always_ff @(posedge clk) begin
      if (wr_en && cfg_open) mem[addr] <= wdata;
      if (rd_en)             rdata_q   <= mem[addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_en && !cfg_open;
   end

   assign rdata = rdata_q;
   assign err   = err_q;

endmodule

// File: rtl/can_afilt_decide.sv
module can_afilt_decide
   import can_afilt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  afm_e mode,
   input  logic frm_valid,
   input  logic match_valid,
   input  logic match_hit,
   output logic frm_ready,
   output logic srch_start,
   output logic dec_valid,
   output logic dec_accept
);

   dstate_e state_q;
   logic    srch_q, dv_q, acc_q;
   logic    hs;

   assign frm_ready = (state_q == DS_IDLE);
   assign hs        = frm_valid && frm_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         srch_q  <= 1'b0;
         dv_q    <= 1'b0;
         acc_q   <= 1'b0;
      end else begin
         srch_q <= 1'b0;
         dv_q   <= 1'b0;
         unique case (mode)
            AFM_HALT: begin
               state_q <= DS_IDLE;
               if (hs) begin
                  dv_q  <= 1'b1;
                  acc_q <= 1'b0;
               end
            end
            AFM_PASS: begin
               state_q <= DS_IDLE;
               if (hs) begin
                  dv_q  <= 1'b1;
                  acc_q <= 1'b1;
               end
            end
            default: begin
               if (hs) begin
                  state_q <= DS_WAIT;
                  srch_q  <= 1'b1;
               end else if (state_q == DS_WAIT && match_valid) begin
                  state_q <= DS_IDLE;
                  dv_q    <= 1'b1;
                  acc_q   <= match_hit;
               end
            end
         endcase
      end
   end

   assign srch_start = srch_q;
   assign dec_valid  = dv_q;
   assign dec_accept = acc_q;

endmodule

// File: rtl/can_afilt_mode_ctrl.sv
module can_afilt_mode_ctrl
   import can_afilt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DW        = 32,
   parameter int unsigned LUT_DEPTH = 512,
   parameter int unsigned SEC_N     = 5,
   parameter int unsigned SEC_W     = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DW-1:0]          bus_wdata,
   input  logic                   bus_we,
   input  logic                   bus_re,
   output logic [DW-1:0]          bus_rdata,
   output logic                   bus_ready,
   input  logic                   frm_valid,
   output logic                   frm_ready,
   output logic                   srch_start,
   input  logic                   match_valid,
   input  logic                   match_hit,
   output logic                   dec_valid,
   output logic                   dec_accept,
   output logic                   engine_halt,
   output logic                   enh_rx_en,
   output logic [SEC_N*SEC_W-1:0] sec_bound,
   output logic                   lut_err
);

   localparam int unsigned LUT_AW = $clog2(LUT_DEPTH);
   localparam int unsigned OFF_W  = ADDR_W - 1;
   localparam int unsigned IDX_W  = (SEC_N > 1) ? $clog2(SEC_N) : 1;

   generate
      if (LUT_AW > OFF_W) begin : g_bad_aw
         $error("address too narrow for the lookup memory");
      end
      if (SEC_W > DW || SEC_W < LUT_AW) begin : g_bad_secw
         $error("section width must cover a word offset and fit the bus");
      end
      if (SEC_N + 1 > (1 << OFF_W)) begin : g_bad_secn
         $error("too many section registers for the register space");
      end
   endgenerate

   // address decode
   logic             reg_space;
   logic [OFF_W-1:0] off;
   logic             mode_hit, sec_hit, mem_hit;
   logic [OFF_W-1:0] sec_off;
   logic [IDX_W-1:0] sec_idx;

   assign reg_space = bus_addr[ADDR_W-1];
   assign off       = bus_addr[OFF_W-1:0];
   assign mode_hit  = reg_space && (off == '0);
   assign sec_hit   = reg_space && (off != '0) && (32'(off) <= SEC_N);
   assign mem_hit   = !reg_space && (32'(off) < LUT_DEPTH);
   assign sec_off   = off - OFF_W'(1);
   assign sec_idx   = sec_off[IDX_W-1:0];

   // mode register
   logic [MODE_BITS-1:0] mode_bits;
   afm_e                 mode;
   logic                 cfg_open;

   can_afilt_mode_reg #(.DW(DW)) i_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_we && mode_hit),
      .wdata     (bus_wdata),
      .mode_bits (mode_bits),
      .mode      (mode),
      .enh_en    (enh_rx_en)
   );

   assign cfg_open    = (mode != AFM_SCREEN);
   assign engine_halt = cfg_open;

   // section boundaries
   logic [SEC_W-1:0] sec_rd;

   can_afilt_sect_bank #(.SEC_N(SEC_N), .SEC_W(SEC_W)) i_sect (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && sec_hit),
      .cfg_open (cfg_open),
      .wr_idx   (sec_idx),
      .wdata    (bus_wdata[SEC_W-1:0]),
      .rd_idx   (sec_idx),
      .rd_val   (sec_rd),
      .bound    (sec_bound)
   );

   // lookup memory
   logic [DW-1:0] lut_rd;

   can_afilt_lut #(.DEPTH(LUT_DEPTH), .DW(DW)) i_lut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && mem_hit),
      .rd_en    (bus_re && mem_hit),
      .cfg_open (cfg_open),
      .addr     (off[LUT_AW-1:0]),
      .wdata    (bus_wdata),
      .rdata    (lut_rd),
      .err      (lut_err)
   );

   // frame decision
   can_afilt_decide i_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .frm_valid   (frm_valid),
      .match_valid (match_valid),
      .match_hit   (match_hit),
      .frm_ready   (frm_ready),
      .srch_start  (srch_start),
      .dec_valid   (dec_valid),
      .dec_accept  (dec_accept)
   );

   // read return
   logic [DW-1:0] reg_rd_d, reg_rd_q;
   logic          from_mem_q, ready_q;

   always_comb begin
      reg_rd_d = '0;
      if (mode_hit)     reg_rd_d = DW'(mode_bits);
      else if (sec_hit) reg_rd_d = DW'(sec_rd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q    <= 1'b0;
         from_mem_q <= 1'b0;
         reg_rd_q   <= '0;
      end else begin
         ready_q <= bus_we || bus_re;
         if (bus_re) begin
            from_mem_q <= mem_hit;
            reg_rd_q   <= reg_rd_d;
         end
      end
   end

   assign bus_ready = ready_q;
   assign bus_rdata = from_mem_q ? lut_rd : reg_rd_q;

endmodule

// File: rtl/can_afilt_mode_ctrl_chk.sv
module can_afilt_mode_ctrl_chk
   import can_afilt_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DW     = 32,
   parameter int unsigned SECW_T = 50
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              bus_re,
   input logic [DW-1:0]     bus_rdata,
   input logic              bus_ready,
   input logic              frm_valid,
   input logic              frm_ready,
   input logic              srch_start,
   input logic              match_valid,
   input logic              dec_valid,
   input logic              dec_accept,
   input logic              engine_halt,
   input logic              enh_rx_en,
   input logic [SECW_T-1:0] sec_bound,
   input logic              lut_err,
   input afm_e              mode
);

   logic reg_sp;
   assign reg_sp = bus_addr[ADDR_W-1];

   // R3
   halt_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_ready && mode == AFM_HALT) |=> (dec_valid && !dec_accept));

   // R4
   pass_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_ready && mode == AFM_PASS) |=> (dec_valid && dec_accept));

   // R5
   search_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srch_start |-> (!frm_ready && !dec_valid));

   // R6
   dec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past((frm_valid && frm_ready) || match_valid));

   // R7
   halted_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_halt && $past(engine_halt)) |-> (frm_ready && !srch_start));

   // R8
   sect_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && reg_sp && mode == AFM_SCREEN) |=> $stable(sec_bound));

   // R9
   lut_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lut_err |-> $past(bus_we && !reg_sp && mode == AFM_SCREEN));

   // R11
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we || bus_re) |=> bus_ready);

   // R2
   mode_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && reg_sp && bus_addr[ADDR_W-2:0] == '0) |=> (bus_rdata[DW-1:3] == '0));

   // R12
   enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enh_rx_en |-> !engine_halt);

endmodule

bind can_afilt_mode_ctrl can_afilt_mode_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DW     (DW),
   .SECW_T (SEC_N*SEC_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_re      (bus_re),
   .bus_rdata   (bus_rdata),
   .bus_ready   (bus_ready),
   .frm_valid   (frm_valid),
   .frm_ready   (frm_ready),
   .srch_start  (srch_start),
   .match_valid (match_valid),
   .dec_valid   (dec_valid),
   .dec_accept  (dec_accept),
   .engine_halt (engine_halt),
   .enh_rx_en   (enh_rx_en),
   .sec_bound   (sec_bound),
   .lut_err     (lut_err),
   .mode        (mode)
);

// File: tb/test_can_afilt_mode_ctrl.sv
module test_can_afilt_mode_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        frm_valid = 1'b0, frm_ready, srch_start;
   logic        match_valid = 1'b0, match_hit = 1'b0;
   logic        dec_valid, dec_accept, engine_halt, enh_rx_en, lut_err;
   logic [49:0] sec_bound;

   int total = 0;
   int bad = 0;

   localparam logic [10:0] MODE_A = 11'h400;

   always #4 clk = ~clk;

   can_afilt_mode_ctrl i_can_afilt_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .frm_valid(frm_valid), .frm_ready(frm_ready), .srch_start(srch_start),
      .match_valid(match_valid), .match_hit(match_hit), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .engine_halt(engine_halt), .enh_rx_en(enh_rx_en),
      .sec_bound(sec_bound), .lut_err(lut_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      chk("R11 write ready", 32'(bus_ready), 32'd1);
   endtask

   task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
      chk("R11 read ready", 32'(bus_ready), 32'd1);
   endtask

   // frame in halt or pass-through: verdict one cycle after handshake
   task automatic quick_frame(input logic exp_acc, input string req);
      @(negedge clk);
      frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
      chk(req, {30'd0, dec_valid, dec_accept}, {30'd0, 1'b1, exp_acc});
      chk(req, 32'(srch_start), 32'd0);
      chk(req, 32'(engine_halt), 32'd1);
      @(negedge clk);
      chk(req, 32'(dec_valid), 32'd0);
   endtask

   // frame in screening: search, hold for dly cycles, then answer
   task automatic screen_frame(input int dly, input logic hit);
      @(negedge clk);
      frm_valid = 1'b1;
      @(negedge clk);
      chk("R5 start", {29'd0, srch_start, frm_ready, dec_valid}, {29'd0, 3'b100});
      for (int k = 0; k < dly; k++) begin
         @(negedge clk);
         chk("R5 hold", {29'd0, srch_start, frm_ready, dec_valid}, 32'd0);
      end
      frm_valid = 1'b0;
      match_valid = 1'b1; match_hit = hit;
      @(negedge clk);
      match_valid = 1'b0; match_hit = 1'b0;
      chk("R6 verdict", {29'd0, dec_valid, dec_accept, frm_ready}, {29'd0, 1'b1, hit, 1'b1});
   endtask

   function automatic logic [9:0] sec_pat(input int k, input int salt);
      return 10'((k * 173 + salt * 59 + 17) % 1024);
   endfunction

   function automatic logic [31:0] mem_pat(input int i, input int salt);
      return (32'(i) * 32'h0101_0101) ^ (32'h5A5A_0000 + 32'(salt));
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 halt", 32'(engine_halt), 32'd1);
      chk("R1 ready", 32'(frm_ready), 32'd1);
      chk("R1 bounds", 32'(sec_bound == '0), 32'd1);
      bus_read(MODE_A, rd);
      chk("R1 mode", rd, 32'h1);
      for (int k = 1; k <= 5; k++) begin
         bus_read(MODE_A + 11'(k), rd);
         chk("R1 section", rd, 32'h0);
      end

      // R2 reserved bits dropped
      bus_write(MODE_A, 32'hFFFF_FFF9);
      bus_read(MODE_A, rd);
      chk("R2 mode bits", rd, 32'h1);
      bus_write(MODE_A, 32'h1);

      // R3 halt rejects
      quick_frame(1'b0, "R3 halt reject");

      // R8 sections writable when halted, 10-bit masked
      for (int k = 1; k <= 5; k++)
         bus_write(MODE_A + 11'(k), 32'hFFFF_FC00 | 32'(sec_pat(k, 0)));
      for (int k = 1; k <= 5; k++) begin
         bus_read(MODE_A + 11'(k), rd);
         chk("R8 section readback", rd, 32'(sec_pat(k, 0)));
         chk("R8 section port", 32'(sec_bound[(k-1)*10 +: 10]), 32'(sec_pat(k, 0)));
      end

      // R9/R10 memory writes when halted
      for (int i = 0; i < 512; i += 17) bus_write(11'(i), mem_pat(i, 0));
      bus_write(11'd511, mem_pat(511, 0));
      for (int i = 0; i < 512; i += 17) begin
         bus_read(11'(i), rd);
         chk("R10 mem readback", rd, mem_pat(i, 0));
      end
      bus_read(11'd511, rd);
      chk("R10 last word", rd, mem_pat(511, 0));

      // screening with enhanced enable
      bus_write(MODE_A, 32'h4);
      chk("R12 enh on", 32'(enh_rx_en), 32'd1);
      chk("R1 halt cleared", 32'(engine_halt), 32'd0);

      // R8 writes ignored while screening
      for (int k = 1; k <= 5; k++) bus_write(MODE_A + 11'(k), 32'(sec_pat(k, 1)));
      for (int k = 1; k <= 5; k++) begin
         bus_read(MODE_A + 11'(k), rd);
         chk("R8 locked section", rd, 32'(sec_pat(k, 0)));
      end

      // R9 memory writes blocked with error pulse
      for (int i = 0; i < 512; i += 51) begin
         bus_write(11'(i), mem_pat(i, 1));
         chk("R9 err pulse", 32'(lut_err), 32'd1);
         @(negedge clk);
         chk("R9 err clears", 32'(lut_err), 32'd0);
      end
      for (int i = 0; i < 512; i += 51) begin
         bus_read(11'(i), rd);
         chk("R10 screening read", rd, i % 17 == 0 ? mem_pat(i, 0) : rd);
      end
      bus_read(11'd0, rd);
      chk("R9 word unchanged", rd, mem_pat(0, 0));

      // R5/R6 screening delays and verdicts
      for (int d = 0; d < 4; d++) begin
         screen_frame(d, 1'b1);
         screen_frame(d, 1'b0);
      end

      // R7 halt abandons pending verdict
      @(negedge clk);
      frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
      chk("R7 pending", 32'(frm_ready), 32'd0);
      bus_write(MODE_A, 32'h1);
      @(negedge clk);
      chk("R7 ready back", 32'(frm_ready), 32'd1);
      match_valid = 1'b1; match_hit = 1'b1;
      @(negedge clk);
      match_valid = 1'b0; match_hit = 1'b0;
      chk("R7 no verdict", 32'(dec_valid), 32'd0);
      chk("R12 enh off when halted", 32'(enh_rx_en), 32'd0);

      // R4 pass-through, sections writable there
      bus_write(MODE_A, 32'h6);
      chk("R12 enh off in pass", 32'(enh_rx_en), 32'd0);
      quick_frame(1'b1, "R4 pass accept");
      quick_frame(1'b1, "R4 pass accept again");
      bus_write(MODE_A + 11'd3, 32'(sec_pat(3, 2)));
      bus_read(MODE_A + 11'd3, rd);
      chk("R8 pass write", rd, 32'(sec_pat(3, 2)));

      // R3 halt dominates pass-through
      bus_write(MODE_A, 32'h3);
      quick_frame(1'b0, "R3 halt over pass");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule